// File: doc/BRIEF.md
# Width-Adapting Bus Bridge with Wait States

This block sits between a processor data port and a set of memory-mapped devices whose data paths are 8, 16 or 32 bits wide. A request of 8, 16 or 32 bits is cut into as many device-width accesses as the target region needs. Each access holds the device bus for that region's cycle count. The pieces of a read are merged into one result. Addresses are 24 bits wide, and on 32-bit transfers only the low 24 data bits carry meaning: the top byte is zeroed on the way out and dropped on the way back.

Three regions are decoded from a fixed table. The first is a 32-bit scratch RAM with a parameterised wait. The second is a 16-bit flash area whose wait comes from a control input, and which takes only 16-bit writes. The third is an 8-bit display buffer with a parameterised wait. An address outside all three, an undefined size code, or a flash write of the wrong size completes at once with an error and never reaches the device bus.

Handshake: the requester raises `req_valid` with address, size, direction and write data, and holds all of them stable until `req_ready` is seen. The bridge works on one request at a time, and a request stalls for the whole length of its device accesses. `req_ready` is the only back-pressure; there is no queue. In the cycle after `req_ready`, the requester must either drop `req_valid` or present its next request, because any valid seen then is accepted as new.

Top module: `bus_width_bridge`

## Requirements
- R1: The region table decodes as follows, with `dev_sel` bit i selecting region i. Region 0 is 0x000000–0x007FFF: 32 bits wide, `RAM_WAIT` cycles (default 1). Region 1 is 0x008000–0x087FFF: 16 bits wide. Region 2 is 0x088000–0x08FFFF: 8 bits wide, `DISP_WAIT` cycles (default 2). Exactly one bit of `dev_sel` is high while `dev_en` is high.
- R2: Size codes on `req_size` and `dev_size` are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. A request wider than the region is split into request/region accesses of region width. These accesses go out lowest address first, and the address rises by the region width in bytes. A request no wider than the region makes one access of the request's own size at the request address.
- R3: `dev_en` stays high for exactly (cycles per access × number of accesses) consecutive clocks. `req_ready` rises in the clock that follows the last of them.
- R4: The region 1 cycle count is `flash_wait` for values 1 to 5. A value of 0 gives 1 and values 6 and 7 give 5.
- R5: Read pieces are merged little-endian: access k fills result bits starting at k × region width. Only `dev_size` bytes of `dev_rdata` are used, and 8- and 16-bit results are zero-extended.
- R6: On a 32-bit read, `req_rdata[31:24]` is 0 whatever the device returns.
- R7: On a 32-bit write, the bytes the device receives for bits 31:24 of `req_wdata` are 0.
- R8: A byte or 32-bit write to region 1 causes no device access and completes one clock after acceptance with `req_err` high. Reads of any size from region 1 are served normally.
- R9: An unmapped address or size code 3 causes no device access and completes one clock after acceptance with `req_err` high and `req_rdata` 0.
- R10: `req_ready` is high for exactly one clock per request, and `req_rdata` and `req_err` are valid in that clock.
- R11: `req_rdata` is 0 whenever `req_ready` is low and on the completion of any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | Size code (0/1/2 = 8/16/32 bit) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, little-endian |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Merged read result |
| req_err | output | 1 | Error flag, valid with req_ready |
| flash_wait | input | 3 | Region 1 cycles per access |
| dev_en | output | 1 | Device access in progress |
| dev_sel | output | 3 | One-hot region select |
| dev_we | output | 1 | Device write |
| dev_addr | output | 24 | Device byte address |
| dev_size | output | 2 | Device access size code |
| dev_wdata | output | 32 | Device write data, low lanes |
| dev_rdata | input | 32 | Device read data, low lanes |

## Verification
The bench runs every pairing of request size and region width, in both directions and at two offsets. These cases separate the three split counts (one, two and four accesses) and the two merge shifts, and they show whether the address step follows the region width. Each access's device read word carries garbage in the unused lanes, so an unmasked lane or a kept top byte shows up in the result. A sweep of `flash_wait` from 0 to 7 tells the clamping ends apart from the pass-through values. Reads at the first and last byte of each region check that the decoder limits are inclusive. Writes of every size to the flash area, to unmapped space and with size code 3 check that only legal traffic reaches the device. After each of these, the bench compares the memory bytes next to the target with their old values.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int AW   = 24;
  localparam int DW   = 32;
  localparam int NREG = 3;
  localparam int CW   = 3;
  localparam int FLASH_WAIT_MAX = 5;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_NONE = 2'd3;

  // region table, index = dev_sel bit
  localparam logic [NREG-1:0][AW-1:0] REG_BASE  = {24'h088000, 24'h008000, 24'h000000};
  localparam logic [NREG-1:0][AW-1:0] REG_LIMIT = {24'h08FFFF, 24'h087FFF, 24'h007FFF};
  localparam logic [NREG-1:0][1:0]    REG_WIDTH = {SZ_BYTE, SZ_HALF, SZ_WORD};
  localparam logic [NREG-1:0]         REG_FLASH = 3'b010;

  typedef struct packed {
    logic [AW-1:0]   addr;
    logic [DW-1:0]   wd;
    logic [NREG-1:0] sel;
    logic [1:0]      sub;
    logic [1:0]      nlast;
    logic [CW-1:0]   cyc;
    logic            we;
    logic [1:0]      rsize;
  } xfer_t;
endpackage

// File: rtl/bwb_decode.sv
module bwb_decode
  import bwb_pkg::*;
#(
  parameter int RAM_WAIT  = 1,
  parameter int DISP_WAIT = 2
) (
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      size,
  input  logic            write,
  input  logic [CW-1:0]   flash_wait,
  output logic [NREG-1:0] sel,
  output logic [1:0]      wcode,
  output logic [CW-1:0]   cyc,
  output logic            illegal
);
  localparam logic [CW-1:0] RAM_CYC  = CW'(RAM_WAIT);
  localparam logic [CW-1:0] DISP_CYC = CW'(DISP_WAIT);
  localparam logic [CW-1:0] FL_MAX   = CW'(FLASH_WAIT_MAX);

  logic [NREG-1:0]         hit;
  logic [CW-1:0]           flash_cyc;
  logic [NREG-1:0][CW-1:0] wait_tab;
  logic                    is_flash;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_hit
    assign hit[gi] = (addr >= REG_BASE[gi]) && (addr <= REG_LIMIT[gi]);
  end

  always_comb begin
    if (flash_wait == '0)        flash_cyc = CW'(1);
    else if (flash_wait > FL_MAX) flash_cyc = FL_MAX;
    else                         flash_cyc = flash_wait;
  end

  assign wait_tab = {DISP_CYC, flash_cyc, RAM_CYC};

  always_comb begin
    wcode    = SZ_WORD;
    cyc      = CW'(1);
    is_flash = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        wcode    = REG_WIDTH[i];
        cyc      = wait_tab[i];
        is_flash = REG_FLASH[i];
      end
    end
  end

  assign sel     = hit;
  assign illegal = (hit == '0) || (size == SZ_NONE) ||
                   (is_flash && write && (size != SZ_HALF));
endmodule

// File: rtl/bwb_lane.sv
module bwb_lane
  import bwb_pkg::*;
(
  input  logic [1:0]    sub,
  input  logic [1:0]    beat,
  input  logic [DW-1:0] wd,
  input  logic [DW-1:0] bus_rd,
  output logic [DW-1:0] bus_wd,
  output logic [DW-1:0] rd_part
);
  logic [4:0]    sh;
  logic [DW-1:0] mask;

  assign sh = {beat, 3'b000} << sub;

  always_comb begin
    case (sub)
      SZ_BYTE: mask = DW'(32'h0000_00FF);
      SZ_HALF: mask = DW'(32'h0000_FFFF);
      default: mask = {DW{1'b1}};
    endcase
  end

  assign bus_wd  = (wd >> sh) & mask;
  assign rd_part = (bus_rd & mask) << sh;
endmodule

// File: rtl/bwb_seq.sv
module bwb_seq
  import bwb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            illegal,
  input  logic [1:0]      size,
  input  logic [1:0]      wcode,
  input  logic [CW-1:0]   cyc,
  input  logic [NREG-1:0] sel,
  input  logic [AW-1:0]   addr,
  input  logic            write,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   rd_part,
  output logic            busy,
  output logic [NREG-1:0] bus_sel,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [1:0]      bus_size,
  output logic [1:0]      beat,
  output logic [DW-1:0]   wd_hold,
  output logic            done,
  output logic            fault,
  output logic [DW-1:0]   result
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DONE} st_e;

  localparam logic [DW-1:0] TOP_DROP = {8'h00, {(DW-8){1'b1}}};

  st_e           st;
  xfer_t         x;
  logic [1:0]    k;
  logic [CW-1:0] cnt;
  logic [DW-1:0] acc;
  logic          err_q;
  logic [1:0]    sub_d;
  logic [2:0]    ncount;
  logic          last_cyc;

  assign sub_d    = (size < wcode) ? size : wcode;
  assign ncount   = 3'd1 << (size - sub_d);
  assign last_cyc = (cnt == x.cyc - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      x     <= '0;
      k     <= '0;
      cnt   <= '0;
      acc   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          acc <= '0;
          k   <= '0;
          cnt <= '0;
          if (illegal) begin
            err_q <= 1'b1;
            st    <= ST_DONE;
          end else begin
            err_q   <= 1'b0;
            x.addr  <= addr;
            x.wd    <= (size == SZ_WORD) ? (wdata & TOP_DROP) : wdata;
            x.sel   <= sel;
            x.sub   <= sub_d;
            x.nlast <= 2'(ncount - 3'd1);
            x.cyc   <= cyc;
            x.we    <= write;
            x.rsize <= size;
            st      <= ST_ACC;
          end
        end
        ST_ACC: begin
          if (last_cyc) begin
            cnt <= '0;
            if (!x.we) acc <= acc | rd_part;
            if (k == x.nlast) st <= ST_DONE;
            else              k  <= k + 2'd1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st == ST_ACC);
  assign bus_sel  = busy ? x.sel : '0;
  assign bus_we   = busy && x.we;
  assign bus_addr = x.addr + (AW'(k) << x.sub);
  assign bus_size = x.sub;
  assign beat     = k;
  assign wd_hold  = x.wd;
  assign done     = (st == ST_DONE);
  assign fault    = done && err_q;
  assign result   = done ? ((x.rsize == SZ_WORD) ? (acc & TOP_DROP) : acc) : '0;
endmodule

// File: rtl/bus_width_bridge.sv
module bus_width_bridge
  import bwb_pkg::*;
#(
  parameter int RAM_WAIT  = 1,
  parameter int DISP_WAIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic [DW-1:0]   req_rdata,
  output logic            req_err,
  input  logic [CW-1:0]   flash_wait,
  output logic            dev_en,
  output logic [NREG-1:0] dev_sel,
  output logic            dev_we,
  output logic [AW-1:0]   dev_addr,
  output logic [1:0]      dev_size,
  output logic [DW-1:0]   dev_wdata,
  input  logic [DW-1:0]   dev_rdata
);
  logic [NREG-1:0] dec_sel;
  logic [1:0]      dec_wcode;
  logic [CW-1:0]   dec_cyc;
  logic            dec_illegal;
  logic [1:0]      beat;
  logic [DW-1:0]   wd_hold;
  logic [DW-1:0]   rd_part;

  bwb_decode #(.RAM_WAIT(RAM_WAIT), .DISP_WAIT(DISP_WAIT)) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write), .flash_wait(flash_wait),
    .sel(dec_sel), .wcode(dec_wcode), .cyc(dec_cyc), .illegal(dec_illegal)
  );

  bwb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .illegal(dec_illegal),
    .size(req_size), .wcode(dec_wcode), .cyc(dec_cyc), .sel(dec_sel),
    .addr(req_addr), .write(req_write), .wdata(req_wdata), .rd_part(rd_part),
    .busy(dev_en), .bus_sel(dev_sel), .bus_we(dev_we), .bus_addr(dev_addr),
    .bus_size(dev_size), .beat(beat), .wd_hold(wd_hold), .done(req_ready),
    .fault(req_err), .result(req_rdata)
  );

  bwb_lane u_lane (
    .sub(dev_size), .beat(beat), .wd(wd_hold), .bus_rd(dev_rdata),
    .bus_wd(dev_wdata), .rd_part(rd_part)
  );
endmodule

// File: rtl/bwb_chk.sv
module bwb_chk
  import bwb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            req_err,
  input logic [DW-1:0]   req_rdata,
  input logic [1:0]      req_size,
  input logic            dev_en,
  input logic            dev_we,
  input logic [NREG-1:0] dev_sel,
  input logic [AW-1:0]   dev_addr,
  input logic [1:0]      dev_size,
  input logic [DW-1:0]   dev_wdata
);
  assert_one_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_en |-> $countones(dev_sel) == 1);

  assert_addr_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_en && $past(dev_en) && (dev_addr != $past(dev_addr))) |-> (dev_addr > $past(dev_addr)));

  assert_bus_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dev_en);

  assert_top_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_size == SZ_WORD) |-> req_rdata[DW-1:DW-8] == 8'h00);

  assert_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_en && dev_we && dev_size == SZ_WORD) |-> dev_wdata[DW-1:DW-8] == 8'h00);

  assert_flash_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_en && dev_we && dev_sel[1]) |-> dev_size == SZ_HALF);

  assert_err_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_ready);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> req_rdata == '0);
endmodule

bind bus_width_bridge bwb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .req_rdata(req_rdata), .req_size(req_size), .dev_en(dev_en), .dev_we(dev_we),
  .dev_sel(dev_sel), .dev_addr(dev_addr), .dev_size(dev_size), .dev_wdata(dev_wdata)
);

// File: tb/sim_bus_width_bridge.sv
`timescale 1ns/1ps
module sim_bus_width_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_write, req_ready, req_err;
  logic [23:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata, req_rdata;
  logic [2:0]  flash_wait;
  logic        dev_en, dev_we;
  logic [2:0]  dev_sel;
  logic [23:0] dev_addr;
  logic [1:0]  dev_size;
  logic [31:0] dev_wdata, dev_rdata;

  bus_width_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .req_err(req_err),
    .flash_wait(flash_wait), .dev_en(dev_en), .dev_sel(dev_sel), .dev_we(dev_we),
    .dev_addr(dev_addr), .dev_size(dev_size), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  // three 64-byte device windows, index = region*64 + (addr & 63)
  logic [7:0] mem [0:191];
  logic       reload;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  function automatic logic [7:0] pat(input int r, input int i);
    return 8'((i * 37 + r * 11 + 5) | 1);
  endfunction

  function automatic int ridx(input logic [2:0] s);
    return s[0] ? 0 : (s[1] ? 1 : 2);
  endfunction

  always @(posedge clk) begin
    if (reload) begin
      for (int i = 0; i < 192; i++) mem[i] <= pat(i / 64, i % 64);
    end else if (dev_en && dev_we) begin
      for (int b = 0; b < 4; b++)
        if (b < (1 << dev_size))
          mem[ridx(dev_sel) * 64 + int'((dev_addr + 24'(b)) & 24'h3F)] <= dev_wdata[8*b +: 8];
    end
  end

  always @* begin
    for (int b = 0; b < 4; b++)
      dev_rdata[8*b +: 8] = mem[ridx(dev_sel) * 64 + int'((dev_addr + 24'(b)) & 24'h3F)];
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // results of the last transaction
  logic [31:0] got_rdata;
  logic        got_err, got, post_ready;
  int          en_cnt, lat;
  logic [23:0] first_a, last_a;
  logic [2:0]  sel_seen;
  logic [1:0]  sz_seen;

  task automatic do_reload();
    @(negedge clk) reload = 1'b1;
    @(negedge clk) reload = 1'b0;
  endtask

  task automatic txn(input logic [23:0] a, input logic [1:0] sz, input bit we,
                     input logic [31:0] wd);
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = we; req_wdata = wd; req_valid = 1'b1;
    en_cnt = 0; lat = 0; got = 1'b0; first_a = '0; last_a = '0; sel_seen = '0; sz_seen = '0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      lat++;
      if (req_ready) begin
        got_rdata = req_rdata; got_err = req_err; got = 1'b1;
        break;
      end
      if (dev_en) begin
        if (en_cnt == 0) begin first_a = dev_addr; sel_seen = dev_sel; sz_seen = dev_size; end
        last_a = dev_addr;
        en_cnt++;
      end
    end
    req_valid = 1'b0;
    chk(got, "R10", "completion seen", 32'(got), 32'd1);
    @(negedge clk);
    post_ready = req_ready;
  endtask

  function automatic int wcode_of(input int r);
    return (r == 0) ? 2 : ((r == 1) ? 1 : 0);
  endfunction

  function automatic int cyc_of(input int r, input int fw);
    if (r == 0) return 1;
    if (r == 2) return 2;
    if (fw == 0) return 1;
    if (fw > 5) return 5;
    return fw;
  endfunction

  task automatic run_read(input int r, input logic [23:0] a, input int sz, input int fw);
    int w, sub, n, cyc;
    logic [31:0] exp;
    w = wcode_of(r); sub = (sz < w) ? sz : w; n = 1 << (sz - sub); cyc = cyc_of(r, fw);
    exp = '0;
    for (int j = 0; j < (1 << sz); j++)
      exp |= 32'(pat(r, int'((a + 24'(j)) & 24'h3F))) << (8 * j);
    if (sz == 2) exp &= 32'h00FF_FFFF;
    flash_wait = 3'(fw);
    do_reload();
    txn(a, 2'(sz), 1'b0, 32'h0);
    chk(got_err == 1'b0, "R8", "legal read err", 32'(got_err), 32'd0);
    chk(got_rdata == exp, "R5", "merged read", got_rdata, exp);
    if (sz == 2) chk(got_rdata[31:24] == 8'h00, "R6", "top byte dropped", got_rdata, exp);
    chk(en_cnt == cyc * n, (r == 1) ? "R4" : "R3", "bus cycles", 32'(en_cnt), 32'(cyc * n));
    chk(lat == en_cnt + 1, "R3", "ready after last access", 32'(lat), 32'(en_cnt + 1));
    chk(first_a == a, "R2", "first address", 32'(first_a), 32'(a));
    chk(last_a == a + 24'((n - 1) << sub), "R2", "last address", 32'(last_a),
        32'(a + 24'((n - 1) << sub)));
    chk(sz_seen == 2'(sub), "R2", "device size", 32'(sz_seen), 32'(sub));
    chk(sel_seen == 3'(1 << r), "R1", "region select", 32'(sel_seen), 32'(1 << r));
    chk(post_ready == 1'b0, "R10", "ready one clock", 32'(post_ready), 32'd0);
  endtask

  task automatic run_write(input int r, input logic [23:0] a, input int sz, input logic [31:0] wd);
    int w, sub, n, nb, idx;
    logic [7:0] eb;
    w = wcode_of(r); sub = (sz < w) ? sz : w; n = 1 << (sz - sub); nb = 1 << sz;
    flash_wait = 3'd2;
    do_reload();
    txn(a, 2'(sz), 1'b1, wd);
    if (r == 1 && sz != 1) begin
      chk(got_err == 1'b1, "R8", "flash bad size err", 32'(got_err), 32'd1);
      chk(en_cnt == 0, "R8", "no device access", 32'(en_cnt), 32'd0);
      chk(lat == 1, "R8", "one clock completion", 32'(lat), 32'd1);
      for (int j = 0; j < 4; j++) begin
        idx = r * 64 + int'((a + 24'(j)) & 24'h3F);
        chk(mem[idx] == pat(r, idx % 64), "R8", "flash unchanged", 32'(mem[idx]), 32'(pat(r, idx % 64)));
      end
    end else begin
      chk(got_err == 1'b0, "R8", "legal write err", 32'(got_err), 32'd0);
      chk(got_rdata == 32'h0, "R11", "write rdata zero", got_rdata, 32'h0);
      chk(en_cnt == 2 * n * cyc_of(r, 2) / 2, "R3", "write bus cycles", 32'(en_cnt), 32'(n * cyc_of(r, 2)));
      for (int j = 0; j <= nb; j++) begin
        idx = r * 64 + int'((a + 24'(j)) & 24'h3F);
        if (j == nb) eb = pat(r, idx % 64);
        else if (sz == 2 && j == 3) eb = 8'h00;
        else eb = wd[8*j +: 8];
        chk(mem[idx] == eb, (sz == 2 && j == 3) ? "R7" : "R2", "written byte", 32'(mem[idx]), 32'(eb));
      end
    end
  endtask

  task automatic run_bad(input logic [23:0] a, input int sz, input bit we);
    txn(a, 2'(sz), we, 32'hDEAD_BEEF);
    chk(got_err == 1'b1, "R9", "error flag", 32'(got_err), 32'd1);
    chk(got_rdata == 32'h0, "R9", "zero data", got_rdata, 32'h0);
    chk(en_cnt == 0, "R9", "no device access", 32'(en_cnt), 32'd0);
    chk(lat == 1, "R9", "one clock completion", 32'(lat), 32'd1);
    chk(post_ready == 1'b0, "R10", "ready one clock", 32'(post_ready), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] bases [3];
    bases[0] = 24'h000010; bases[1] = 24'h008020; bases[2] = 24'h088010;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; flash_wait = 3'd2; reload = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10", "reset ready", 32'(req_ready), 32'd0);
    chk(dev_en == 1'b0, "R3", "reset dev_en", 32'(dev_en), 32'd0);
    chk(req_rdata == 32'h0, "R11", "reset rdata", req_rdata, 32'h0);
    rst_n = 1'b1; reload = 1'b0;

    // size x region x offset, reads and writes
    for (int r = 0; r < 3; r++)
      for (int sz = 0; sz < 3; sz++)
        for (int o = 0; o < 16; o += 8) begin
          run_read(r, bases[r] + 24'(o), sz, 2);
          run_write(r, bases[r] + 24'(o), sz, 32'hA1B2C3D4 ^ 32'(o * 16'h0101 + sz));
        end

    // flash cycle setting sweep
    for (int fw = 0; fw < 8; fw++) begin
      run_read(1, 24'h008004, 2, fw);
      run_read(1, 24'h008006, 1, fw);
    end

    // region edges
    run_read(0, 24'h007FFC, 2, 3);
    run_read(0, 24'h007FFF, 0, 3);
    run_read(1, 24'h008000, 1, 3);
    run_read(1, 24'h087FFE, 1, 3);
    run_read(1, 24'h087FFF, 0, 3);
    run_read(2, 24'h088000, 2, 3);
    run_read(2, 24'h08FFFF, 0, 3);

    // unmapped and bad size
    run_bad(24'h090000, 0, 1'b0);
    run_bad(24'h100000, 2, 1'b1);
    run_bad(24'hFFFFFF, 1, 1'b0);
    run_bad(24'h000010, 3, 1'b0);
    run_bad(24'h088010, 3, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule